// File: doc/BRIEF.md
# Standby Entry and Exit Clock Sequencer

This block steps a processor core into a light low-power standby and brings it back out. A single-cycle idle request from the CPU starts the sequence. The system clock keeps running for a flush interval whose length follows the 2-bit divider select, so the pipeline can drain. After that interval the system, CPU and peripheral clock enables go low. The PLL enable and the watchdog clock enable stay high the whole time.

A short blanking window follows the gating. During the flush and the blanking window, wake-up activity is thrown away. Once the block is in standby, the wake-up input passes through a synchronizer and a pulse-width qualifier. A wake pulse that qualifies starts a fixed exit latency. The clocks come back at the start of that latency. On its last cycle a one-cycle resume pulse is issued, together with an interrupt-service pulse when the interrupt enable is set.

All pins are plain control and status levels or single-cycle pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `stby_seq_ctrl`

## Requirements
- R1: After an idle request is accepted, `sys_clk_en` stays high for exactly 16 cycles when the select is 00 or 01, 32 when it is 10 and 64 when it is 11 (the FLUSH_BASE default of 16 scales by 1, 1, 2, 4). The select is captured in the cycle of the request.
- R2: While gated, `sys_clk_en`, `cpu_clk_en` and `per_clk_en` are 0 and `standby` is 1. `pll_en` and `wdog_clk_en` are 1 in every state.
- R3: After gating, a blanking window of BLANK_CYC cycles (default 5) passes before wake-up is armed. A wake pulse that occurs during the flush or the blanking window, and ends before arming, has no effect.
- R4: `wake_in` is sampled through a SYNC_STAGES flop chain (default 2). It counts as a wake event only after WAKE_MIN consecutive synchronized high samples (default 2) taken while armed. A pulse one cycle wide is rejected.
- R5: On a wake event, `standby` falls and all gated enables rise in the same cycle. `resume` is high for exactly one cycle, on the EXIT_LAT-th cycle (default 8) with `standby` low. The block is then back in run.
- R6: `irq_go` pulses together with `resume` exactly when `int_en` is 1. It stays 0 otherwise.
- R7: An idle request that arrives outside the run state is ignored. It neither restarts nor lengthens the current sequence.
- R8: While reset is asserted and after its release, the block is in run: every clock enable is 1, and `standby`, `resume` and `irq_go` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle request to enter standby |
| div_sel | input | 2 | Divider select; sets the flush length |
| wake_in | input | 1 | Asynchronous wake-up level |
| int_en | input | 1 | Interrupt enable, sampled at resume |
| sys_clk_en | output | 1 | System clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable, always on |
| wdog_clk_en | output | 1 | Watchdog clock enable, always on |
| standby | output | 1 | High while the clocks are gated |
| resume | output | 1 | One-cycle pulse: execution may continue |
| irq_go | output | 1 | One-cycle pulse: pending interrupt may be taken |

## Verification
The bench measures the flush length for every select value. A design that decoded 00 differently from 01, or re-read the select mid-flush, would report a count other than 16/32/64. Wake pulses are placed inside the blanking window, and a design that latched them would leave standby early. One-cycle wake pulses check the width filter, which a design lacking it would accept. Idle requests are issued during the flush and while gated, and a design that honoured them would lengthen the flush. The exit latency and the `irq_go` gating are timed on each resume, so an off-by-one latency or an interrupt pulse with `int_en` low shows up directly.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_FLUSH,
    ST_BLANK,
    ST_STANDBY,
    ST_EXIT
  } stby_state_e;

  // Flush length in oscillator cycles for a divider select value.
  function automatic int unsigned flush_len(input logic [1:0] sel, input int unsigned base);
    case (sel)
      2'b10:   return base * 2;
      2'b11:   return base * 4;
      default: return base;
    endcase
  endfunction
endpackage

// File: rtl/stby_down_cnt.sv
module stby_down_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !zero) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_MIN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_async,
  input  logic arm,
  output logic wake_evt
);
  localparam int HW = (WAKE_MIN < 2) ? 1 : $clog2(WAKE_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES:0]   sync_nxt;
  logic                   wake_s;
  logic [HW-1:0]          hi_cnt;

  assign sync_nxt = {sync_q, wake_async};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt[SYNC_STAGES-1:0];
  end

  assign wake_s = sync_q[SYNC_STAGES-1];

  // Run length of synchronized high samples seen while armed, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n)                               hi_cnt <= '0;
    else if (!arm || !wake_s)                 hi_cnt <= '0;
    else if (hi_cnt != HW'(WAKE_MIN - 1))     hi_cnt <= hi_cnt + HW'(1);
  end

  assign wake_evt = arm && wake_s && (hi_cnt == HW'(WAKE_MIN - 1));

  assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (WAKE_MIN > 1 && wake_evt) |-> ($past(wake_s) && $past(arm)));
endmodule

// File: rtl/stby_en_decode.sv
module stby_en_decode
  import stby_pkg::*;
(
  input  stby_state_e st,
  output logic        sys_clk_en,
  output logic        cpu_clk_en,
  output logic        per_clk_en,
  output logic        pll_en,
  output logic        wdog_clk_en,
  output logic        standby
);
  logic gated;

  always_comb begin
    unique case (st)
      ST_BLANK, ST_STANDBY: gated = 1'b1;
      default:              gated = 1'b0;
    endcase
  end

  assign sys_clk_en  = !gated;
  assign cpu_clk_en  = !gated;
  assign per_clk_en  = !gated;
  assign pll_en      = 1'b1;
  assign wdog_clk_en = 1'b1;
  assign standby     = gated;
endmodule

// File: rtl/stby_seq_ctrl.sv
module stby_seq_ctrl
  import stby_pkg::*;
#(
  parameter int FLUSH_BASE  = 16,
  parameter int BLANK_CYC   = 5,
  parameter int EXIT_LAT    = 8,
  parameter int WAKE_MIN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic [1:0] div_sel,
  input  logic       wake_in,
  input  logic       int_en,
  output logic       sys_clk_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pll_en,
  output logic       wdog_clk_en,
  output logic       standby,
  output logic       resume,
  output logic       irq_go
);
  localparam int FLUSH_MAX = FLUSH_BASE * 4;
  localparam int CNT_MAX0  = (FLUSH_MAX > BLANK_CYC) ? FLUSH_MAX : BLANK_CYC;
  localparam int CNT_MAX   = (CNT_MAX0 > EXIT_LAT) ? CNT_MAX0 : EXIT_LAT;
  localparam int CW        = $clog2(CNT_MAX + 1);

  stby_state_e state_q, state_d;
  logic          cnt_load, cnt_dec, cnt_zero, wake_evt, arm;
  logic [CW-1:0] cnt_val, cnt_q;

  assign arm = (state_q == ST_STANDBY);

  stby_wake_qual #(.SYNC_STAGES(SYNC_STAGES), .WAKE_MIN(WAKE_MIN)) u_wake (
    .clk(clk_osc), .rst_n(rst_n), .wake_async(wake_in), .arm(arm), .wake_evt(wake_evt)
  );

  stby_down_cnt #(.W(CW)) u_cnt (
    .clk(clk_osc), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .cnt(cnt_q), .zero(cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_RUN: if (idle_req) begin
        state_d  = ST_FLUSH;
        cnt_load = 1'b1;
        cnt_val  = CW'(flush_len(div_sel, FLUSH_BASE) - 1);
      end
      ST_FLUSH: if (cnt_zero) begin
        state_d  = ST_BLANK;
        cnt_load = 1'b1;
        cnt_val  = CW'(BLANK_CYC - 1);
      end else cnt_dec = 1'b1;
      ST_BLANK: if (cnt_zero) state_d = ST_STANDBY;
                else          cnt_dec = 1'b1;
      ST_STANDBY: if (wake_evt) begin
        state_d  = ST_EXIT;
        cnt_load = 1'b1;
        cnt_val  = CW'(EXIT_LAT - 1);
      end
      ST_EXIT: if (cnt_zero) state_d = ST_RUN;
               else          cnt_dec = 1'b1;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_osc) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  stby_en_decode u_dec (
    .st(state_q), .sys_clk_en(sys_clk_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pll_en(pll_en), .wdog_clk_en(wdog_clk_en),
    .standby(standby)
  );

  assign resume = (state_q == ST_EXIT) && cnt_zero;
  assign irq_go = resume && int_en;

  // Observation counter for the flush window, independent of the down counter.
  logic [1:0] div_lat;
  logic [CW:0] flush_obs;
  always_ff @(posedge clk_osc) begin
    if (!rst_n) begin
      div_lat   <= 2'b00;
      flush_obs <= '0;
    end else if (state_q == ST_RUN) begin
      flush_obs <= '0;
      if (idle_req) div_lat <= div_sel;
    end else if (state_q == ST_FLUSH) begin
      flush_obs <= flush_obs + 1'b1;
    end
  end

  assert_flush_len_R1: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_BLANK && $past(state_q) == ST_FLUSH)
      |-> (flush_obs == (CW+1)'(flush_len(div_lat, FLUSH_BASE))));

  assert_gated_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_STANDBY) |-> (!per_clk_en && !cpu_clk_en && pll_en && wdog_clk_en));

  assert_blank_drop_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_FLUSH || state_q == ST_BLANK) |-> !wake_evt);

  assert_clk_before_resume_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (EXIT_LAT > 1 && resume) |-> $past(sys_clk_en));

  assert_resume_single_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    resume |=> !resume);

  assert_idle_ignored_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_FLUSH && idle_req && !cnt_zero)
      |=> (state_q == ST_FLUSH && cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: tb/test_stby_seq_ctrl.sv
module test_stby_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n, idle_req, wake_in, int_en;
  logic [1:0] div_sel;
  logic sys_clk_en, cpu_clk_en, per_clk_en, pll_en, wdog_clk_en, standby, resume, irq_go;
  int compared = 0;
  int mismatched = 0;

  localparam int EXIT_LAT = 8;

  always #5 clk = ~clk;

  stby_seq_ctrl i_stby_seq_ctrl (
    .clk_osc(clk), .rst_n(rst_n), .idle_req(idle_req), .div_sel(div_sel),
    .wake_in(wake_in), .int_en(int_en), .sys_clk_en(sys_clk_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pll_en(pll_en),
    .wdog_clk_en(wdog_clk_en), .standby(standby), .resume(resume), .irq_go(irq_go)
  );

  function automatic int exp_flush(input logic [1:0] d);
    if (d == 2'b10) return 32;
    if (d == 2'b11) return 64;
    return 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_run_state(input string req);
    chk(sys_clk_en && cpu_clk_en && per_clk_en && pll_en && wdog_clk_en, req,
        {sys_clk_en, cpu_clk_en, per_clk_en, pll_en, wdog_clk_en}, 31);
    chk(!standby && !resume && !irq_go, req, {standby, resume, irq_go}, 0);
  endtask

  task automatic do_seq(input logic [1:0] d, input bit inten, input bit mid_idle,
                        input bit blank_pulse, input bit short_pulse, input int w);
    int n, t, e;
    @(negedge clk);
    idle_req = 1'b1; div_sel = d; int_en = inten;
    @(negedge clk);
    idle_req = 1'b0;
    n = 0;
    while (sys_clk_en && n < 200) begin
      n++;
      if (mid_idle && n == 3) begin idle_req = 1'b1; div_sel = ~d; end
      else idle_req = 1'b0;
      @(negedge clk);
    end
    idle_req = 1'b0;
    chk(n == exp_flush(d), mid_idle ? "R1/R7 flush length" : "R1 flush length", n, exp_flush(d));
    // now in first gated cycle
    chk(standby && !sys_clk_en && !cpu_clk_en && !per_clk_en, "R2 gated enables",
        {standby, sys_clk_en, cpu_clk_en, per_clk_en}, 8);
    chk(pll_en && wdog_clk_en, "R2 pll/wdog on", {pll_en, wdog_clk_en}, 3);
    if (blank_pulse) begin
      wake_in = 1'b1; @(negedge clk); @(negedge clk); wake_in = 1'b0;
      idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(standby == 1'b1, "R3 blanked wake discarded", standby, 1);
      chk(!sys_clk_en, "R7 idle while gated ignored", sys_clk_en, 0);
    end else begin
      repeat (6) @(negedge clk);
    end
    if (short_pulse) begin
      wake_in = 1'b1; @(negedge clk); wake_in = 1'b0;
      repeat (10) @(negedge clk);
      chk(standby == 1'b1, "R4 one-cycle wake rejected", standby, 1);
    end
    wake_in = 1'b1;
    t = 0;
    while (standby && t < 40) begin
      @(negedge clk);
      t++;
      if (t == w) wake_in = 1'b0;
    end
    wake_in = 1'b0;
    chk(!standby, "R4 qualified wake accepted", standby, 0);
    chk(sys_clk_en && cpu_clk_en && per_clk_en, "R5 clocks back with standby low",
        {sys_clk_en, cpu_clk_en, per_clk_en}, 7);
    e = 0;
    while (e < 30) begin
      e++;
      if (resume) break;
      if (!sys_clk_en || standby) chk(0, "R5 clock during exit", sys_clk_en, 1);
      if (irq_go) chk(0, "R6 irq_go early", irq_go, 0);
      @(negedge clk);
    end
    chk(e == EXIT_LAT, "R5 exit latency", e, EXIT_LAT);
    chk(irq_go == inten, "R6 irq_go gating", irq_go, inten);
    @(negedge clk);
    chk_run_state("R5 back in run, single resume");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; idle_req = 1'b0; wake_in = 1'b0; int_en = 1'b0; div_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk_run_state("R8 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_run_state("R8 after reset");
    // directed corners
    do_seq(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    do_seq(2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    do_seq(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 3);
    do_seq(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 5);
    // constrained random
    for (int i = 0; i < 20; i++) begin
      do_seq(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
             1'($urandom % 2), 1'($urandom % 2), 2 + int'($urandom % 4));
      repeat (int'($urandom % 4)) @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule